// File: doc/BRIEF.md
# Working Register Bank with Data-Space Window and Address Pointers

This block is the general-purpose register bank of a small 8-bit processor core. It holds thirty-two 8-bit registers. Two combinational read ports feed the ALU operands, and a single write port takes the ALU result at the clock edge. Together they let a read-operate-write sequence finish in one clock.

The same registers also sit at the bottom of the data address space. A load or store whose address falls below 32 reaches register n at address n instead of memory, and the block flags that hit so the memory path can stand aside. The top six registers pair up into three 16-bit pointers. These feed the address generators, and the last one also serves as the program-memory table lookup address. A 16-bit write-back port updates a whole pointer in one cycle for auto-increment and auto-decrement addressing. An immediate-form flag restricts the operand field to the upper sixteen registers.

Top module: `cpu_regbank`

## Requirements
- R1: When reset is active (rst_n low, asynchronous), every register clears to zero. After reset, all reads and all three pointers return zero.
- R2: Read ports A and B are combinational and return the register named by their index. A write on the ALU port (alu_we high) is visible on the read ports from the cycle after the clock edge.
- R3: When a register is read in the same cycle that it is written, the read returns the value it held before that edge.
- R4: With imm_form high, the 4-bit field ra_idx[3:0] selects register 16+ra_idx[3:0] on read port A, and alu_widx[3:0] selects register 16+alu_widx[3:0] for the ALU write. Bit 4 of both indices is ignored. Read port B is never affected.
- R5: A data-bus address below 32 raises dbus_hit. dbus_rdata then returns register dbus_addr[4:0], and dbus_we writes dbus_wdata into that register at the clock edge.
- R6: A data-bus address of 32 or above drops dbus_hit and returns zero on dbus_rdata. A dbus_we at such an address changes no register.
- R7: The pointer outputs are X = {R27,R26}, Y = {R29,R28} and Z = {R31,R30}. In each pair the even-numbered register holds the low byte.
- R8: With ptr_we high, ptr_sel 0, 1 or 2 writes ptr_wdata into both bytes of X, Y or Z respectively in one clock. ptr_sel 3 writes nothing.
- R9: When several ports target the same register in one cycle, the ALU port takes priority over pointer write-back, and pointer write-back takes priority over the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_form | input | 1 | Immediate-form flag; maps port A and ALU write into R16..R31 |
| ra_idx | input | 5 | Read port A register index |
| rb_idx | input | 5 | Read port B register index |
| rd_a | output | 8 | Read port A data |
| rd_b | output | 8 | Read port B data |
| alu_we | input | 1 | ALU result write enable |
| alu_widx | input | 5 | ALU result register index |
| alu_wdata | input | 8 | ALU result data |
| ptr_we | input | 1 | Pointer write-back enable |
| ptr_sel | input | 2 | Pointer select: 0 X, 1 Y, 2 Z, 3 none |
| ptr_wdata | input | 16 | Pointer write-back value |
| dbus_addr | input | 16 | Data-space address |
| dbus_we | input | 1 | Data-bus store enable |
| dbus_wdata | input | 8 | Data-bus store data |
| dbus_rdata | output | 8 | Data-bus load data (zero when not hit) |
| dbus_hit | output | 1 | Address falls in the register window |
| x_ptr | output | 16 | Pointer X |
| y_ptr | output | 16 | Pointer Y |
| z_ptr | output | 16 | Pointer Z and table-lookup address |

## Verification
The bench reads a register in the same cycle it writes it. A bank with write-through forwarding would return the new byte there instead of the old one. It drives the ALU and pointer write-back at the same pointer byte, and pointer write-back and a bus store at the same byte. A wrong priority chain would let the lower-priority value land in the register. The immediate-form case uses an index with bit 4 set, which shows whether the design dropped that bit. A bus store to address 32 aliases register 0 in its low bits, so an incomplete window decode would overwrite R0. A swapped byte order within a pointer would show up directly on the X, Y and Z outputs.

// File: rtl/cpu_regbank_pkg.sv
package cpu_regbank_pkg;

  localparam int RB_ENTRIES  = 32;
  localparam int RB_IDX_W    = 5;
  localparam int RB_PTR_BASE = RB_ENTRIES - 6;

  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_id_e;

  // Immediate-form operands only reach the upper half of the bank.
  function automatic logic [RB_IDX_W-1:0] eff_index(input logic [RB_IDX_W-1:0] field,
                                                    input logic imm);
    return imm ? {1'b1, field[RB_IDX_W-2:0]} : field;
  endfunction

  // Low byte of a pointer sits in the even register of its pair.
  function automatic logic [15:0] join_pair(input logic [7:0] lo, input logic [7:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int N = 32,
  parameter int W = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0][W-1:0] arr,
  input  logic [IW-1:0]       idx,
  output logic [W-1:0]        dout
);
  assign dout = arr[idx];
endmodule

// File: rtl/rf_write_mux.sv
module rf_write_mux #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         alu_en,
  input  logic [W-1:0] alu_d,
  input  logic         ptr_en,
  input  logic [W-1:0] ptr_d,
  input  logic         bus_en,
  input  logic [W-1:0] bus_d,
  output logic [W-1:0] q
);
  logic [W-1:0] d_next;

  always_comb begin
    d_next = q;
    if (bus_en) d_next = bus_d;
    if (ptr_en) d_next = ptr_d;
    if (alu_en) d_next = alu_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d_next;
  end

  AST_ALU_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |=> q == $past(alu_d)); // R9
  AST_PTR_OVER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && !alu_en) |=> q == $past(ptr_d)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!alu_en && !ptr_en && !bus_en) |=> $stable(q)); // R2
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
  import cpu_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                imm_form,
  input  logic [4:0]          ra_idx,
  input  logic [4:0]          rb_idx,
  output logic [DATA_W-1:0]   rd_a,
  output logic [DATA_W-1:0]   rd_b,
  input  logic                alu_we,
  input  logic [4:0]          alu_widx,
  input  logic [DATA_W-1:0]   alu_wdata,
  input  logic                ptr_we,
  input  logic [1:0]          ptr_sel,
  input  logic [2*DATA_W-1:0] ptr_wdata,
  input  logic [ADDR_W-1:0]   dbus_addr,
  input  logic                dbus_we,
  input  logic [DATA_W-1:0]   dbus_wdata,
  output logic [DATA_W-1:0]   dbus_rdata,
  output logic                dbus_hit,
  output logic [2*DATA_W-1:0] x_ptr,
  output logic [2*DATA_W-1:0] y_ptr,
  output logic [2*DATA_W-1:0] z_ptr
);
  localparam int NREG  = RB_ENTRIES;
  localparam int IDX_W = RB_IDX_W;
  localparam int PBASE = RB_PTR_BASE;

  logic [NREG-1:0][DATA_W-1:0] regs_q;
  logic [IDX_W-1:0]            a_sel, w_sel;
  logic [IDX_W-1:0]            bus_idx;
  logic [DATA_W-1:0]           bus_word;
  logic                        ptr_valid;
  logic [NREG-1:0]             alu_hit_v, ptr_hit_v, bus_hit_v;
  logic                        z_alu_clash;

  assign a_sel     = eff_index(ra_idx, imm_form);
  assign w_sel     = eff_index(alu_widx, imm_form);
  assign bus_idx   = dbus_addr[IDX_W-1:0];
  assign dbus_hit  = (dbus_addr[ADDR_W-1:IDX_W] == '0);
  assign ptr_valid = ptr_we && (ptr_sel != PTR_NONE);

  rf_read_port #(.N(NREG), .W(DATA_W)) u_rd_a (.arr(regs_q), .idx(a_sel),   .dout(rd_a));
  rf_read_port #(.N(NREG), .W(DATA_W)) u_rd_b (.arr(regs_q), .idx(rb_idx),  .dout(rd_b));
  rf_read_port #(.N(NREG), .W(DATA_W)) u_rd_m (.arr(regs_q), .idx(bus_idx), .dout(bus_word));

  assign dbus_rdata = dbus_hit ? bus_word : '0;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DATA_W-1:0] ptr_byte;
    assign alu_hit_v[i] = alu_we && (w_sel == IDX_W'(i));
    assign bus_hit_v[i] = dbus_we && dbus_hit && (bus_idx == IDX_W'(i));
    if (i >= PBASE) begin : g_ptr
      localparam logic [1:0] PID = 2'((i - PBASE) / 2);
      assign ptr_hit_v[i] = ptr_valid && (ptr_sel == PID);
      if (i % 2 == 0) begin : g_lo
        assign ptr_byte = ptr_wdata[DATA_W-1:0];
      end else begin : g_hi
        assign ptr_byte = ptr_wdata[2*DATA_W-1:DATA_W];
      end
    end else begin : g_noptr
      assign ptr_hit_v[i] = 1'b0;
      assign ptr_byte     = '0;
    end
    rf_write_mux #(.W(DATA_W)) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .alu_en(alu_hit_v[i]),
      .alu_d (alu_wdata),
      .ptr_en(ptr_hit_v[i]),
      .ptr_d (ptr_byte),
      .bus_en(bus_hit_v[i]),
      .bus_d (dbus_wdata),
      .q     (regs_q[i])
    );
  end

  assign x_ptr = join_pair(regs_q[PBASE],   regs_q[PBASE+1]);
  assign y_ptr = join_pair(regs_q[PBASE+2], regs_q[PBASE+3]);
  assign z_ptr = join_pair(regs_q[PBASE+4], regs_q[PBASE+5]);

  assign z_alu_clash = alu_hit_v[PBASE+4] || alu_hit_v[PBASE+5];

  AST_Z_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == PTR_Z && !z_alu_clash) |=> z_ptr == $past(ptr_wdata)); // R8
  AST_BUS_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_we && !dbus_hit && !alu_we && !ptr_we) |=> $stable(regs_q)); // R6
  AST_BUS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_we && dbus_hit && !alu_we && !ptr_we) |=> regs_q[$past(bus_idx)] == $past(dbus_wdata)); // R5
  AST_SEL3_NO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_we && ptr_sel == PTR_NONE && !alu_we && !dbus_we) |=> $stable(regs_q)); // R8
  AST_IMM_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_form && alu_we && !ptr_we && !dbus_we) |=> $stable(regs_q[NREG/2-1:0])); // R4
endmodule

// File: tb/test_cpu_regbank.sv
module test_cpu_regbank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imm_form = 1'b0;
  logic [4:0]  ra_idx = '0, rb_idx = '0;
  logic [7:0]  rd_a, rd_b;
  logic        alu_we = 1'b0;
  logic [4:0]  alu_widx = '0;
  logic [7:0]  alu_wdata = '0;
  logic        ptr_we = 1'b0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] ptr_wdata = '0;
  logic [15:0] dbus_addr = '0;
  logic        dbus_we = 1'b0;
  logic [7:0]  dbus_wdata = '0;
  logic [7:0]  dbus_rdata;
  logic        dbus_hit;
  logic [15:0] x_ptr, y_ptr, z_ptr;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [7:0] mdl [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_regbank i_cpu_regbank (
    .clk(clk), .rst_n(rst_n), .imm_form(imm_form), .ra_idx(ra_idx), .rb_idx(rb_idx),
    .rd_a(rd_a), .rd_b(rd_b), .alu_we(alu_we), .alu_widx(alu_widx), .alu_wdata(alu_wdata),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_wdata(ptr_wdata), .dbus_addr(dbus_addr),
    .dbus_we(dbus_we), .dbus_wdata(dbus_wdata), .dbus_rdata(dbus_rdata), .dbus_hit(dbus_hit),
    .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Apply one clock with the currently driven inputs; the model writes in
  // ascending priority: bus, then pointer, then ALU.
  task automatic step();
    logic [7:0] nxt [32];
    for (int i = 0; i < 32; i++) nxt[i] = mdl[i];
    if (dbus_we && dbus_addr < 16'd32) nxt[dbus_addr[4:0]] = dbus_wdata;
    if (ptr_we && ptr_sel != 2'd3) begin
      nxt[26 + 2*ptr_sel]     = ptr_wdata[7:0];
      nxt[26 + 2*ptr_sel + 1] = ptr_wdata[15:8];
    end
    if (alu_we) nxt[imm_form ? (5'd16 + {1'b0, alu_widx[3:0]}) : alu_widx] = alu_wdata;
    @(posedge clk);
    #1;
    for (int i = 0; i < 32; i++) mdl[i] = nxt[i];
    alu_we = 0; ptr_we = 0; dbus_we = 0; imm_form = 0;
    #1;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < 32; i++) begin
      rb_idx = 5'(i);
      #1;
      chk(req, $sformatf("reg %0d via port B", i), 32'(rd_b), 32'(mdl[i]));
    end
  endtask

  task automatic check_ptrs(input string req);
    chk(req, "x_ptr", 32'(x_ptr), {16'd0, mdl[27], mdl[26]});
    chk(req, "y_ptr", 32'(y_ptr), {16'd0, mdl[29], mdl[28]});
    chk(req, "z_ptr", 32'(z_ptr), {16'd0, mdl[31], mdl[30]});
  endtask

  task automatic t_reset();
    check_bank("R1");
    check_ptrs("R1");
  endtask

  task automatic t_alu_rw();
    for (int i = 0; i < 32; i++) begin
      alu_we = 1; alu_widx = 5'(i); alu_wdata = 8'(8'h3C ^ (i * 7));
      step();
    end
    check_bank("R2");
    ra_idx = 5'd9; rb_idx = 5'd22; #1;
    chk("R2", "port A reg 9", 32'(rd_a), 32'(mdl[9]));
    chk("R2", "port B reg 22", 32'(rd_b), 32'(mdl[22]));
  endtask

  task automatic t_old_read();
    ra_idx = 5'd4; rb_idx = 5'd4;
    alu_we = 1; alu_widx = 5'd4; alu_wdata = 8'hA5; #1;
    chk("R3", "port A during write", 32'(rd_a), 32'(mdl[4]));
    chk("R3", "port B during write", 32'(rd_b), 32'(mdl[4]));
    step();
    chk("R3", "port A after edge", 32'(rd_a), 32'h0A5);
  endtask

  task automatic t_imm();
    imm_form = 1; ra_idx = 5'd5; #1;
    chk("R4", "imm read field 5 -> R21", 32'(rd_a), 32'(mdl[21]));
    ra_idx = 5'd21; #1;
    chk("R4", "imm read ignores bit4", 32'(rd_a), 32'(mdl[21]));
    rb_idx = 5'd5; #1;
    chk("R4", "port B unaffected", 32'(rd_b), 32'(mdl[5]));
    alu_we = 1; alu_widx = 5'd3; alu_wdata = 8'h77;
    step();
    check_bank("R4");
  endtask

  task automatic t_bus();
    dbus_addr = 16'd12; #1;
    chk("R5", "hit at 12", 32'(dbus_hit), 32'd1);
    chk("R5", "load of R12", 32'(dbus_rdata), 32'(mdl[12]));
    dbus_addr = 16'd31; #1;
    chk("R5", "hit at 31", 32'(dbus_hit), 32'd1);
    dbus_addr = 16'd7; dbus_we = 1; dbus_wdata = 8'hD2;
    step();
    rb_idx = 5'd7; #1;
    chk("R5", "store to R7", 32'(rd_b), 32'h0D2);
    dbus_addr = 16'd32; #1;
    chk("R6", "miss at 32", 32'(dbus_hit), 32'd0);
    chk("R6", "load zero at 32", 32'(dbus_rdata), 32'd0);
    dbus_we = 1; dbus_wdata = 8'hEE;
    step();
    dbus_addr = 16'h0100; dbus_we = 1; dbus_wdata = 8'h11;
    step();
    check_bank("R6");
  endtask

  task automatic t_ptr_view();
    for (int i = 26; i < 32; i++) begin
      alu_we = 1; alu_widx = 5'(i); alu_wdata = 8'(8'h10 * (i - 25) + i);
      step();
    end
    check_ptrs("R7");
  endtask

  task automatic t_ptr_wb();
    ptr_we = 1; ptr_sel = 2'd1; ptr_wdata = 16'hBEEF;
    step();
    chk("R8", "y_ptr written", 32'(y_ptr), 32'h0BEEF);
    rb_idx = 5'd28; #1;
    chk("R8", "R28 low byte", 32'(rd_b), 32'h0EF);
    ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'h1234; step();
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'hFEDC; step();
    check_ptrs("R8");
    ptr_we = 1; ptr_sel = 2'd3; ptr_wdata = 16'h5555;
    step();
    check_bank("R8");
  endtask

  task automatic t_priority();
    ptr_we = 1; ptr_sel = 2'd2; ptr_wdata = 16'hA1B2;
    alu_we = 1; alu_widx = 5'd31; alu_wdata = 8'h3E;
    step();
    chk("R9", "alu over ptr on R31", 32'(z_ptr), 32'h03EB2);
    ptr_we = 1; ptr_sel = 2'd0; ptr_wdata = 16'hC0DE;
    dbus_we = 1; dbus_addr = 16'd26; dbus_wdata = 8'h99;
    step();
    chk("R9", "ptr over bus on R26", 32'(x_ptr), 32'h0C0DE);
    alu_we = 1; alu_widx = 5'd2; alu_wdata = 8'h44;
    dbus_we = 1; dbus_addr = 16'd2; dbus_wdata = 8'h55;
    step();
    check_bank("R9");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    check_bank("R1");
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_alu_rw();
    t_old_read();
    t_imm();
    t_bus();
    t_ptr_view();
    t_ptr_wb();
    t_priority();
    rst_n = 0; #1;
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    check_ptrs("R1");
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule